// File: doc/BRIEF.md
# Energy Accumulation Interval Controller

This block sums signed per-sample power into an internal energy sum over a programmable interval. It then hands each interval's result to a user-visible energy register. The interval is measured either in accepted power samples or in zero-crossing strobes, and its length comes from a programmable count. When an interval closes, the block does three things in the same clock edge: it raises a one-cycle ready pulse, it either adds the internal sum to the user register or overwrites the register with it, and it restarts the internal sum from zero.

The user register can be set to clear itself whenever it is read. A reverse-power flag shows the sign of either the total or the fundamental power of the last accepted sample.

Power samples arrive on a valid/ready stream that carries a total and a fundamental value. The block never applies back-pressure: `smp_ready` is always high, and each cycle with `smp_valid` high delivers exactly one sample. A sample is summed only while accumulation is enabled. Outside that window it is consumed and discarded. The zero-crossing strobe, the read strobe and all control inputs are plain level or pulse signals.

Top module: `energy_interval_ctrl`

## Requirements
- R1: After reset, `egy_value` is 0, `egy_ready` is 0 and `rev_flag` is 0.
- R2: Samples are summed and interval events are counted only while `run_en` and `accum_en` are both 1. Otherwise samples and strobes are ignored, and the interval count and the internal sum hold their values.
- R3: With `base_sel`=0, an interval closes on the `intv_len`-th accepted sample, and `egy_ready` is high in the cycle after that sample.
- R4: With `base_sel`=1, an interval closes on the `intv_len`-th zero-crossing strobe. Samples are still summed and never close the interval. A sample that arrives in the same cycle as the closing strobe belongs to the closing interval.
- R5: With `load_sel`=0, each closing interval adds its sum to `egy_value`.
- R6: With `load_sel`=1, each closing interval replaces `egy_value` with its sum.
- R7: With `rdclr_en`=1, a pulse on `egy_read` sets `egy_value` to 0 in the next cycle. With `rdclr_en`=0, a read leaves `egy_value` unchanged.
- R8: When a clearing read and an interval close fall in the same cycle, the clear is applied first: in add mode the new `egy_value` equals that interval's sum.
- R9: `rev_flag` is the sign bit (MSB) of the last accepted sample: of `smp_total` when `sign_sel`=0, and of `smp_fund` when `sign_sel`=1.
- R10: `egy_value` saturates at its signed limits (2^(EW-1)-1 and -2^(EW-1)) instead of wrapping.
- R11: `egy_ready` is high for one cycle per closed interval. Each interval's sum starts from zero.
- R12: An `intv_len` of 0 behaves like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Global run enable |
| accum_en | input | 1 | Energy accumulation enable |
| base_sel | input | 1 | Interval base: 0 samples, 1 zero crossings |
| load_sel | input | 1 | Transfer mode: 0 add, 1 overwrite |
| rdclr_en | input | 1 | Clear the user register when it is read |
| sign_sel | input | 1 | Flag source: 0 total, 1 fundamental |
| intv_len | input | TW | Interval length in events (0 acts as 1) |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready, always 1 |
| smp_total | input | PW | Signed total active power |
| smp_fund | input | PW | Signed fundamental active power |
| zx_strobe | input | 1 | Zero-crossing event pulse |
| egy_read | input | 1 | User register read strobe |
| egy_value | output | EW | Signed user energy register |
| egy_ready | output | 1 | One-cycle pulse per closed interval |
| rev_flag | output | 1 | Reverse-power sign flag |

## Verification
The bench sweeps interval lengths 1 to 5 against positive, negative and extreme sample values in both transfer modes. It computes every expected total by multiplication. A design that counted one event too few or too many would fire the ready pulse on the wrong sample. A design that kept the internal sum across intervals would show the earlier interval's energy in overwrite mode.

The bench also drives a clearing read in the same cycle as an interval close. A design that ordered these two the wrong way would keep the old register value in the sum. Finally, it runs three full-scale intervals in each direction, where a design that wraps on overflow would flip the sign of the register, and it places a sample on the closing zero-crossing strobe, where a design that lost that sample would come up short.

// File: rtl/ei_pkg.sv
package ei_pkg;
  typedef enum logic {BASE_SAMPLE = 1'b0, BASE_ZX = 1'b1} ei_base_e;
  typedef enum logic {LOAD_ADD = 1'b0, LOAD_OVERWRITE = 1'b1} ei_load_e;
endpackage

// File: rtl/ei_sat_add.sv
module ei_sat_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] wide;
  assign wide = {a[W-1], a} + {b[W-1], b};

  always_comb begin
    if (wide[W] != wide[W-1]) begin
      y = wide[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      y = wide[W-1:0];
    end
  end
endmodule

// File: rtl/ei_interval_timer.sv
module ei_interval_timer
  import ei_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  ei_base_e      base_i,
  input  logic [TW-1:0] len_i,
  input  logic          smp_i,
  input  logic          zx_i,
  output logic          end_o
);
  localparam int CW = TW + 1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim;
  logic [CW-1:0] cnt_nx;
  logic          evt;

  assign lim    = (len_i == '0) ? TW'(1) : len_i;
  assign evt    = active_i && ((base_i == BASE_ZX) ? zx_i : smp_i);
  assign cnt_nx = {1'b0, cnt_q} + CW'(1);
  assign end_o  = evt && (cnt_nx >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (end_o) begin
      cnt_q <= '0;
    end else if (evt) begin
      cnt_q <= cnt_nx[TW-1:0];
    end
  end

  // R4: in zero-crossing mode only a strobe can close an interval
  assert_zx_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (base_i == BASE_ZX && !zx_i) |-> !end_o);

  // R2: the interval count holds while inactive
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> $stable(cnt_q));
endmodule

// File: rtl/ei_accum.sv
module ei_accum #(
  parameter int PW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          smp_i,
  input  logic [PW-1:0] pwr_i,
  input  logic          end_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] acc_q;
  logic [AW-1:0] addend;
  logic          take;

  assign take   = active_i && smp_i;
  assign addend = take ? {{(AW-PW){pwr_i[PW-1]}}, pwr_i} : '0;

  ei_sat_add #(.W(AW)) u_acc_add (.a(acc_q), .b(addend), .y(sum_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (end_i) begin
      acc_q <= '0;
    end else if (take) begin
      acc_q <= sum_o;
    end
  end

  // R11: every interval starts from an empty sum
  assert_restart_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    end_i |=> (acc_q == '0));

  // R2: no summing while inactive
  assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> $stable(acc_q));
endmodule

// File: rtl/ei_user_reg.sv
module ei_user_reg
  import ei_pkg::*;
#(
  parameter int AW = 32,
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_i,
  input  ei_load_e      load_i,
  input  logic          rdclr_i,
  input  logic [AW-1:0] sum_i,
  output logic [EW-1:0] egy_o
);
  logic [EW-1:0] egy_q;
  logic [EW-1:0] sum_ext;
  logic [EW-1:0] base;
  logic [EW-1:0] added;

  assign sum_ext = {{(EW-AW){sum_i[AW-1]}}, sum_i};
  assign base    = rdclr_i ? '0 : egy_q;
  assign egy_o   = egy_q;

  ei_sat_add #(.W(EW)) u_user_add (.a(base), .b(sum_ext), .y(added));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      egy_q <= '0;
    end else if (xfer_i) begin
      egy_q <= (load_i == LOAD_OVERWRITE) ? sum_ext : added;
    end else if (rdclr_i) begin
      egy_q <= '0;
    end
  end

  // R6: overwrite mode leaves exactly the interval sum
  assert_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && load_i == LOAD_OVERWRITE) |=> (egy_q == $past(sum_ext)));

  // R7: a clearing read with no transfer empties the register
  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdclr_i && !xfer_i) |=> (egy_q == '0));

  // R10: adding a non-negative sum never lowers the register
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && load_i == LOAD_ADD && !rdclr_i && !sum_ext[EW-1])
    |=> ($signed(egy_q) >= $signed($past(egy_q))));
endmodule

// File: rtl/energy_interval_ctrl.sv
module energy_interval_ctrl
  import ei_pkg::*;
#(
  parameter int PW = 16,
  parameter int AW = 32,
  parameter int EW = 40,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          accum_en,
  input  logic          base_sel,
  input  logic          load_sel,
  input  logic          rdclr_en,
  input  logic          sign_sel,
  input  logic [TW-1:0] intv_len,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [PW-1:0] smp_total,
  input  logic [PW-1:0] smp_fund,
  input  logic          zx_strobe,
  input  logic          egy_read,
  output logic [EW-1:0] egy_value,
  output logic          egy_ready,
  output logic          rev_flag
);
  logic          active;
  logic          intv_end;
  logic [AW-1:0] intv_sum;
  logic          rdy_q;
  logic          rev_q;

  assign active    = run_en && accum_en;
  assign smp_ready = 1'b1;

  ei_interval_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .active_i(active),
    .base_i  (ei_base_e'(base_sel)),
    .len_i   (intv_len),
    .smp_i   (smp_valid),
    .zx_i    (zx_strobe),
    .end_o   (intv_end)
  );

  ei_accum #(.PW(PW), .AW(AW)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .active_i(active),
    .smp_i   (smp_valid),
    .pwr_i   (smp_total),
    .end_i   (intv_end),
    .sum_o   (intv_sum)
  );

  ei_user_reg #(.AW(AW), .EW(EW)) u_user (
    .clk    (clk),
    .rst_n  (rst_n),
    .xfer_i (intv_end),
    .load_i (ei_load_e'(load_sel)),
    .rdclr_i(egy_read && rdclr_en),
    .sum_i  (intv_sum),
    .egy_o  (egy_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      rev_q <= 1'b0;
    end else begin
      rdy_q <= intv_end;
      if (active && smp_valid) begin
        rev_q <= sign_sel ? smp_fund[PW-1] : smp_total[PW-1];
      end
    end
  end

  assign egy_ready = rdy_q;
  assign rev_flag  = rev_q;

  // R3: a ready pulse always follows a counted event while enabled
  assert_ready_after_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    egy_ready |-> $past(run_en && accum_en && (base_sel ? zx_strobe : smp_valid)));

  // R9: the flag takes the selected sign of an accepted sample
  assert_sign_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && smp_valid) |=> (rev_flag == $past(sign_sel ? smp_fund[PW-1] : smp_total[PW-1])));
endmodule

// File: tb/energy_interval_ctrl_bench.sv
module energy_interval_ctrl_bench;
  localparam int PW = 8;
  localparam int AW = 12;
  localparam int EW = 12;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_en = 1'b0, accum_en = 1'b0, base_sel = 1'b0, load_sel = 1'b0;
  logic          rdclr_en = 1'b0, sign_sel = 1'b0;
  logic [TW-1:0] intv_len = '0;
  logic          smp_valid = 1'b0, zx_strobe = 1'b0, egy_read = 1'b0;
  logic [PW-1:0] smp_total = '0, smp_fund = '0;
  logic          smp_ready, egy_ready, rev_flag;
  logic [EW-1:0] egy_value;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  energy_interval_ctrl #(.PW(PW), .AW(AW), .EW(EW), .TW(TW)) u_energy_interval_ctrl (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .accum_en(accum_en),
    .base_sel(base_sel), .load_sel(load_sel), .rdclr_en(rdclr_en), .sign_sel(sign_sel),
    .intv_len(intv_len), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_total(smp_total), .smp_fund(smp_fund), .zx_strobe(zx_strobe),
    .egy_read(egy_read), .egy_value(egy_value), .egy_ready(egy_ready), .rev_flag(rev_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int egy();
    return int'($signed(egy_value));
  endfunction

  // one clock: drive at a falling edge, return at the next falling edge
  task automatic step(input bit v, input int tot, input int fund, input bit z, input bit r);
    smp_valid = v; smp_total = tot[PW-1:0]; smp_fund = fund[PW-1:0];
    zx_strobe = z; egy_read = r;
    @(negedge clk);
    smp_valid = 1'b0; zx_strobe = 1'b0; egy_read = 1'b0;
  endtask

  initial begin
    int vals[4];
    vals[0] = 5; vals[1] = -9; vals[2] = 127; vals[3] = -128;
    @(negedge clk); @(negedge clk);
    chk("R1 value", egy(), 0);
    chk("R1 ready", int'(egy_ready), 0);
    chk("R1 flag", int'(rev_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stream ready", int'(smp_ready), 1);

    // R3 R5 R6 R11 sweep in sample mode
    run_en = 1'b1; accum_en = 1'b1; rdclr_en = 1'b1; base_sel = 1'b0;
    for (int ld = 0; ld < 2; ld++) begin
      for (int n = 1; n <= 5; n++) begin
        for (int vi = 0; vi < 4; vi++) begin
          int v1, v2;
          v1 = vals[vi]; v2 = vals[(vi + 1) % 4];
          load_sel = ld[0]; intv_len = n[TW-1:0];
          step(0, 0, 0, 0, 1);
          chk("R7 clear", egy(), 0);
          for (int k = 0; k < n; k++) begin
            step(1, v1, 0, 0, 0);
            chk("R3 ready timing", int'(egy_ready), (k == n - 1) ? 1 : 0);
          end
          chk("R3 interval sum", egy(), n * v1);
          for (int k = 0; k < n; k++) step(1, v2, 0, 0, 0);
          if (ld == 0) chk("R5 add", egy(), n * v1 + n * v2);
          else         chk("R6 overwrite R11 restart", egy(), n * v2);
          step(0, 0, 0, 0, 0);
          chk("R11 single pulse", int'(egy_ready), 0);
        end
      end
    end

    // R8 clearing read on the closing cycle
    load_sel = 1'b0; intv_len = 4'd2;
    step(0, 0, 0, 0, 1);
    step(1, 25, 0, 0, 0); step(1, 25, 0, 0, 0);
    chk("R5 add base", egy(), 50);
    step(1, 4, 0, 0, 0); step(1, 6, 0, 0, 1);
    chk("R8 clear then transfer", egy(), 10);

    // R7 read without clear enable
    rdclr_en = 1'b0;
    step(0, 0, 0, 0, 1);
    chk("R7 read no clear", egy(), 10);

    // R2 disabled accumulation
    run_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(1, 100, 0, 0, 0);
      chk("R2 run off ready", int'(egy_ready), 0);
    end
    run_en = 1'b1; accum_en = 1'b0;
    for (int k = 0; k < 3; k++) step(1, 100, 0, 0, 0);
    chk("R2 accum off value", egy(), 10);
    accum_en = 1'b1;
    step(1, 1, 0, 0, 0);
    chk("R2 count paused", int'(egy_ready), 0);
    step(1, 2, 0, 0, 0);
    chk("R2 sum excludes ignored", egy(), 13);

    // R12 zero length
    load_sel = 1'b1; intv_len = '0;
    step(1, 7, 0, 0, 0);
    chk("R12 ready", int'(egy_ready), 1);
    chk("R12 value", egy(), 7);
    step(1, -3, 0, 0, 0);
    chk("R12 second", egy(), -3);

    // R9 sign selection (zero-crossing base so no interval closes)
    base_sel = 1'b1; intv_len = 4'd3;
    sign_sel = 1'b0; step(1, -5, 5, 0, 0); chk("R9 total neg", int'(rev_flag), 1);
    sign_sel = 1'b1; step(1, -5, 5, 0, 0); chk("R9 fund pos", int'(rev_flag), 0);
    step(1, 5, -5, 0, 0); chk("R9 fund neg", int'(rev_flag), 1);
    sign_sel = 1'b0; step(1, 5, -5, 0, 0); chk("R9 total pos", int'(rev_flag), 0);

    // R4 zero-crossing base (pending sum is 0 here)
    step(1, 10, 0, 0, 0); chk("R4 sample no close", int'(egy_ready), 0);
    step(0, 0, 0, 1, 0);  chk("R4 zx one", int'(egy_ready), 0);
    step(1, 20, 0, 0, 0); step(1, 30, 0, 0, 0);
    step(0, 0, 0, 1, 0);  chk("R4 zx two", int'(egy_ready), 0);
    step(1, 1, 0, 0, 0);  step(1, 1, 0, 0, 0);
    chk("R4 samples ignored by count", int'(egy_ready), 0);
    step(1, 5, 0, 1, 0);
    chk("R4 close on zx", int'(egy_ready), 1);
    chk("R4 sum incl. closing sample", egy(), 67);

    // R10 saturation
    base_sel = 1'b0; load_sel = 1'b0; intv_len = 4'd8; rdclr_en = 1'b1;
    step(0, 0, 0, 0, 1);
    for (int i = 1; i <= 3; i++) begin
      for (int k = 0; k < 8; k++) step(1, 127, 0, 0, 0);
      chk("R10 positive", egy(), (i * 1016 > 2047) ? 2047 : i * 1016);
    end
    step(0, 0, 0, 0, 1);
    for (int i = 1; i <= 3; i++) begin
      for (int k = 0; k < 8; k++) step(1, -128, 0, 0, 0);
      chk("R10 negative", egy(), (i * -1024 < -2048) ? -2048 : i * -1024);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule